// File: doc/BRIEF.md
# Indexed RGB Palette Register File

This block is a color lookup table for a display pipeline. Each of its entries holds an 18-bit color: a 6-bit red, a 6-bit green and a 6-bit blue component. A processor programs the table through a narrow, byte-wide register interface with three registers: a write-index register, a read-index register and a shared data register.

Data-port accesses are sequenced, not addressed. After an index is loaded, three consecutive data accesses move red, then green, then blue. A hidden component counter tracks the position in that sequence. Once blue is done, the relevant index advances by itself. Software can therefore stream the whole table after setting the write index once.

A second, independent port on the pixel side turns a pixel index into its 18-bit color one clock later. Its output only ever shows complete entries.

Top module: `clut_regfile`

## Requirements
- R1: After reset, both indices are 0 and the component counter points at red. Every entry reads back as 0, and the pixel output is 0.
- R2: The register select `cpu_sel` is decoded as follows: 0 is the write index, 1 is the read index, 2 is the data port and 3 selects nothing. A write to either index register loads the low IDX_W bits of `cpu_wdata` and restarts the component counter at red.
- R3: Three consecutive data-port writes load red, green and blue, in that order, into the entry at the write index. Only bits 5:0 of each byte are used; bits 7:6 are ignored.
- R4: After the blue write, the write index increments by one and wraps from its highest value to 0. The next triplet therefore lands in the following entry with no reprogramming.
- R5: Red and green are held in staging and are committed together with blue. An entry with only one or two components written keeps its old value, both at the pixel port and on read-back.
- R6: Consecutive data-port reads return red, green and blue of the entry at the read index. Each value is zero-extended into bits 5:0 and appears in the same cycle as the read strobe. After the blue read, the read index increments and wraps to 0.
- R7: A data-port access in the direction opposite to the previous data-port access restarts the sequence at red.
- R8: `pix_color` carries the entry at `pix_idx` one cycle later, packed as red in bits 17:12, green in 11:6 and blue in 5:0. Pixel lookups never change the CPU-side sequence.
- R9: When `cpu_wr` and `cpu_rd` are both high, the write is performed and the read is ignored. `cpu_rdata` is 0 in every cycle that is not a data-port read.
- R10: An access with `cpu_sel` = 3 changes no index, no counter and no entry, and a read with it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 2 | Register select |
| cpu_wr | input | 1 | Write strobe, one access per cycle high |
| cpu_rd | input | 1 | Read strobe, one access per cycle high |
| cpu_wdata | input | 8 | Write data byte |
| cpu_rdata | output | 8 | Read data byte, valid in the strobe cycle |
| pix_idx | input | IDX_W | Pixel-side entry index |
| pix_color | output | 18 | Pixel-side color, one cycle latency |

## Verification
The bench builds the block with IDX_W = 4, which gives a 16-entry table. With that size, a full streamed load, the wrap of both indices from 15 to 0 and a check of every entry fit in a few hundred cycles. The component width keeps its default of 6, so the masking of bits 7:6 on writes and the zero-extension on reads are exercised exactly as in the full-size table.

// File: rtl/clut_pkg.sv
package clut_pkg;
    typedef enum logic [1:0] {
        SEL_WIDX = 2'd0,
        SEL_RIDX = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        C_RED = 2'd0,
        C_GRN = 2'd1,
        C_BLU = 2'd2
    } comp_e;

    typedef enum logic {
        DIR_WR = 1'b0,
        DIR_RD = 1'b1
    } dir_e;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            sel_i,
    input  logic                  wr_i,
    input  logic                  rd_i,
    input  logic [7:0]            wdata_i,
    output logic [7:0]            rdata_o,
    output logic [IDX_W-1:0]      raddr_o,
    input  logic [3*COMP_W-1:0]   rcolor_i,
    output logic                  we_o,
    output logic [IDX_W-1:0]      waddr_o,
    output logic [3*COMP_W-1:0]   wcolor_o
);
    localparam int PAD_W = 8 - COMP_W;

    typedef struct packed {
        logic [IDX_W-1:0]  widx;
        logic [IDX_W-1:0]  ridx;
        comp_e             comp;
        dir_e              dir;
        logic [COMP_W-1:0] stage_r;
        logic [COMP_W-1:0] stage_g;
    } seq_t;

    seq_t  st_q, st_d;
    comp_e wr_step, rd_step;
    logic  is_data;

    always_comb begin
        st_d     = st_q;
        we_o     = 1'b0;
        wcolor_o = {st_q.stage_r, st_q.stage_g, wdata_i[COMP_W-1:0]};
        rdata_o  = '0;
        is_data  = (sel_i == SEL_DATA);
        wr_step  = (st_q.dir == DIR_WR) ? st_q.comp : C_RED;
        rd_step  = (st_q.dir == DIR_RD) ? st_q.comp : C_RED;

        if (wr_i) begin
            case (sel_i)
                SEL_WIDX: begin
                    st_d.widx = wdata_i[IDX_W-1:0];
                    st_d.comp = C_RED;
                    st_d.dir  = DIR_WR;
                end
                SEL_RIDX: begin
                    st_d.ridx = wdata_i[IDX_W-1:0];
                    st_d.comp = C_RED;
                    st_d.dir  = DIR_RD;
                end
                SEL_DATA: begin
                    st_d.dir = DIR_WR;
                    case (wr_step)
                        C_RED: begin
                            st_d.stage_r = wdata_i[COMP_W-1:0];
                            st_d.comp    = C_GRN;
                        end
                        C_GRN: begin
                            st_d.stage_g = wdata_i[COMP_W-1:0];
                            st_d.comp    = C_BLU;
                        end
                        default: begin
                            we_o      = 1'b1;
                            st_d.widx = st_q.widx + 1'b1;
                            st_d.comp = C_RED;
                        end
                    endcase
                end
                default: ;
            endcase
        end else if (rd_i && is_data) begin
            st_d.dir = DIR_RD;
            case (rd_step)
                C_RED: begin
                    rdata_o   = {{PAD_W{1'b0}}, rcolor_i[3*COMP_W-1:2*COMP_W]};
                    st_d.comp = C_GRN;
                end
                C_GRN: begin
                    rdata_o   = {{PAD_W{1'b0}}, rcolor_i[2*COMP_W-1:COMP_W]};
                    st_d.comp = C_BLU;
                end
                default: begin
                    rdata_o   = {{PAD_W{1'b0}}, rcolor_i[COMP_W-1:0]};
                    st_d.ridx = st_q.ridx + 1'b1;
                    st_d.comp = C_RED;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{widx: '0, ridx: '0, comp: C_RED, dir: DIR_WR,
                      stage_r: '0, stage_g: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr_o = st_q.ridx;
    assign waddr_o = st_q.widx;

    AST_WIDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_WIDX) |=>
            (st_q.widx == $past(wdata_i[IDX_W-1:0]) && st_q.comp == C_RED)); // R2

    AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_DATA && st_q.dir == DIR_WR && st_q.comp == C_BLU) |=>
            (st_q.widx == IDX_W'($past(st_q.widx) + 1'b1))); // R4

    AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wr_i && sel_i == SEL_DATA && st_q.dir == DIR_RD && st_q.comp == C_BLU) |=>
            (st_q.ridx == IDX_W'($past(st_q.ridx) + 1'b1))); // R6

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel_i == SEL_DATA) |=>
            ($stable(st_q.stage_r) && $stable(st_q.stage_g))); // R3
endmodule

// File: rtl/clut_store.sv
module clut_store #(
    parameter int IDX_W   = 8,
    parameter int COLOR_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [IDX_W-1:0]   waddr_i,
    input  logic [COLOR_W-1:0] wcolor_i,
    input  logic [IDX_W-1:0]   raddr_i,
    output logic [COLOR_W-1:0] rcolor_o,
    input  logic [IDX_W-1:0]   pix_idx_i,
    output logic [COLOR_W-1:0] pix_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [COLOR_W-1:0] mem_q [DEPTH];
    logic [COLOR_W-1:0] mem_d [DEPTH];
    logic [COLOR_W-1:0] pix_q, pix_d;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_i) begin
            mem_d[waddr_i] = wcolor_i;
        end
        pix_d = mem_q[pix_idx_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            pix_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
            pix_q <= pix_d;
        end
    end

    assign rcolor_o = mem_q[raddr_i];
    assign pix_o    = pix_q;

    AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(we_i) && $stable(pix_idx_i)) |=> $stable(pix_q)); // R8
endmodule

// File: rtl/clut_regfile.sv
module clut_regfile
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cpu_sel,
    input  logic                cpu_wr,
    input  logic                cpu_rd,
    input  logic [7:0]          cpu_wdata,
    output logic [7:0]          cpu_rdata,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic [3*COMP_W-1:0] pix_color
);
    localparam int COLOR_W = 3 * COMP_W;

    logic               we;
    logic [IDX_W-1:0]   waddr, raddr;
    logic [COLOR_W-1:0] wcolor, rcolor;

    clut_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (cpu_sel),
        .wr_i     (cpu_wr),
        .rd_i     (cpu_rd),
        .wdata_i  (cpu_wdata),
        .rdata_o  (cpu_rdata),
        .raddr_o  (raddr),
        .rcolor_i (rcolor),
        .we_o     (we),
        .waddr_o  (waddr),
        .wcolor_o (wcolor)
    );

    clut_store #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (we),
        .waddr_i   (waddr),
        .wcolor_i  (wcolor),
        .raddr_i   (raddr),
        .rcolor_o  (rcolor),
        .pix_idx_i (pix_idx),
        .pix_o     (pix_color)
    );

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd && !cpu_wr && cpu_sel == SEL_DATA) |-> (cpu_rdata == 8'h00)); // R9
endmodule

// File: tb/clut_regfile_tb.sv
module clut_regfile_tb;
    localparam int IDX_W = 4;
    localparam int DEPTH = 1 << IDX_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cpu_sel = 2'd3;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic [IDX_W-1:0] pix_idx = '0;
    logic [17:0] pix_color;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        bit          is_pix;
        logic [17:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    clut_regfile #(.IDX_W(IDX_W), .COMP_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .pix_idx(pix_idx), .pix_color(pix_color)
    );

    always #10 clk = ~clk;

    function automatic logic [17:0] col(input int r, input int g, input int b);
        return {6'(r), 6'(g), 6'(b)};
    endfunction

    function automatic logic [17:0] ramp(input int i);
        return col((i * 3 + 1) & 63, (i * 5 + 7) & 63, (63 - i) & 63);
    endfunction

    // monitor: compares queued expectations shortly before the next edge
    initial begin
        forever begin
            @(negedge clk);
            #8;
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [17:0] act;
                e = exp_q.pop_front();
                act = e.is_pix ? pix_color : {10'd0, cpu_rdata};
                n_run++;
                if (act !== e.val) begin
                    n_fail++;
                    $display("FAIL %s: %s actual %h expected %h", e.tag,
                             e.is_pix ? "pix_color" : "cpu_rdata", act, e.val);
                end
            end
        end
    end

    task automatic push(input bit is_pix, input logic [17:0] v, input string tag);
        exp_t e;
        e.is_pix = is_pix; e.val = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = s; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic wr_rgb(input logic [17:0] c);
        wr(2'd2, {2'b00, c[17:12]});
        wr(2'd2, {2'b00, c[11:6]});
        wr(2'd2, {2'b00, c[5:0]});
    endtask

    task automatic rd(input logic [1:0] s, input logic [7:0] ex, input string tag);
        @(negedge clk);
        cpu_sel = s; cpu_rd = 1'b1;
        push(0, {10'd0, ex}, tag);
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic rd_rgb(input logic [17:0] c, input string tag);
        rd(2'd2, {2'b00, c[17:12]}, tag);
        rd(2'd2, {2'b00, c[11:6]}, tag);
        rd(2'd2, {2'b00, c[5:0]}, tag);
    endtask

    task automatic pix(input int i, input logic [17:0] ex, input string tag);
        @(negedge clk);
        pix_idx = IDX_W'(i);
        @(negedge clk);
        push(1, ex, tag);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_rgb(col(0, 0, 0), "R1 reset entry 0");
        pix(5, 18'd0, "R1 reset pixel");

        // R3, R6: load entry 3, top bits of bytes ignored
        wr(2'd0, 8'd3);
        wr(2'd2, 8'h15); wr(2'd2, 8'hEA); wr(2'd2, 8'hC7);
        pix(3, col(6'h15, 6'h2A, 6'h07), "R3 entry 3 via pixel");
        wr(2'd1, 8'd3);
        rd_rgb(col(6'h15, 6'h2A, 6'h07), "R6 readback entry 3");

        // R4: next triplet lands in entry 4 without index write
        wr_rgb(col(9, 10, 11));
        pix(4, col(9, 10, 11), "R4 auto-increment to entry 4");

        // R5: partial entry not visible
        wr(2'd0, 8'd5);
        wr(2'd2, 8'h11); wr(2'd2, 8'h22);
        pix(5, 18'd0, "R5 partial entry hidden at pixel port");
        wr(2'd1, 8'd5);
        rd(2'd2, 8'h00, "R5 partial entry hidden on readback");
        wr(2'd0, 8'd5);
        wr_rgb(col(6'h11, 6'h22, 6'h33));
        pix(5, col(6'h11, 6'h22, 6'h33), "R5 entry committed on blue");

        // R7: direction change restarts the sequence
        wr(2'd1, 8'd4);
        wr(2'd0, 8'd6);
        wr(2'd2, 8'h01);
        rd(2'd2, 8'd9, "R7 read after write starts at red");
        wr_rgb(col(10, 11, 12));
        pix(6, col(10, 11, 12), "R7 write after read starts at red");
        rd(2'd2, 8'd9, "R7 read restarts at red again");

        // R2: rewriting write index restarts counter
        wr(2'd0, 8'd7);
        wr(2'd2, 8'h10);
        wr(2'd0, 8'd7);
        wr_rgb(col(6'h21, 6'h22, 6'h23));
        pix(7, col(6'h21, 6'h22, 6'h23), "R2 index write restarts at red");

        // R10: select 3 ignored
        wr(2'd0, 8'd8);
        wr(2'd2, 8'd1);
        wr(2'd3, 8'h3F);
        rd(2'd3, 8'h00, "R10 read of select 3 returns 0");
        wr(2'd2, 8'd2); wr(2'd2, 8'd3);
        pix(8, col(1, 2, 3), "R10 select 3 access left sequence intact");

        // R9: simultaneous write and read, write wins
        wr(2'd0, 8'd9);
        @(negedge clk);
        cpu_sel = 2'd2; cpu_wdata = 8'd5; cpu_wr = 1'b1; cpu_rd = 1'b1;
        push(0, 18'd0, "R9 rdata zero when write wins");
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
        wr(2'd2, 8'd6); wr(2'd2, 8'd7);
        pix(9, col(5, 6, 7), "R9 write performed during both strobes");

        // R4, R6: full streamed load with wrap
        wr(2'd0, 8'd0);
        for (int i = 0; i < DEPTH; i++) wr_rgb(ramp(i));
        wr_rgb(col(6'h2C, 6'h1D, 6'h0E));
        pix(0, col(6'h2C, 6'h1D, 6'h0E), "R4 write index wrapped to 0");
        for (int i = 1; i < DEPTH; i++) pix(i, ramp(i), "R4 streamed entry");
        wr(2'd1, 8'(DEPTH - 1));
        rd_rgb(ramp(DEPTH - 1), "R6 readback last entry");
        rd(2'd2, 8'h2C, "R6 read index wrapped to 0");

        // R8: pixel lookup concurrent with CPU reads
        wr(2'd1, 8'd2);
        @(negedge clk);
        cpu_sel = 2'd2; cpu_rd = 1'b1; pix_idx = IDX_W'(4);
        push(0, {10'd0, 8'(ramp(2) >> 12)}, "R8 cpu read beside pixel lookup");
        @(negedge clk);
        cpu_rd = 1'b0;
        push(1, ramp(4), "R8 pixel one-cycle latency");
        rd(2'd2, {2'b00, ramp(2)[11:6]}, "R8 cpu sequence undisturbed");

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule